// File: doc/BRIEF.md
# Min/Max Window Averaging Code Filter

This block smooths the control word of a tracking oscillator before that word reaches a second oscillator, the one that makes the output clock. Once per reference cycle the acquisition controller presents a 12-bit control code with a valid strobe. The code is formed as the coarse field in the upper six bits and the fine field in the lower six bits, and it is treated as one unsigned number. The filter gathers a window of `WIN_LEN` valid samples and records the largest and the smallest code in that window. When the window closes, it loads the midpoint of the two extremes into a held output register.

A tracking loop that dithers between neighbouring codes therefore gives a steady output code, and that dither does not appear as jitter on the output clock. Every window starts afresh from its own first sample. The output changes only when a window completes, and a single-cycle update strobe marks each new value.

Top module: `codeMidFilter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outCode` is mid-scale (2048 for 12 bits) and `updStrobe` is 0.
- R2: `outCode` keeps its reset value, and `updStrobe` stays low, until `WIN_LEN` valid samples have been taken (default 8).
- R3: On the clock edge that takes the last valid sample of a window, `outCode` is loaded with floor((max + min) / 2) of that window's samples. `updStrobe` is 1 for exactly that one following cycle.
- R4: A cycle with `codeValid` low is ignored. It neither advances the window nor affects the extremes, whatever `codeIn` carries.
- R5: Each window's extremes come only from its own samples. Nothing is carried over from the previous window.
- R6: The last sample of a window takes part in that window's max/min, in the same cycle as the output is loaded.
- R7: The sum is formed at 13 bits, so full-scale codes do not overflow. For example, 4095 and 4094 give 4094, and 4095 and 0 give 2047.
- R8: Between updates `outCode` holds its value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| codeValid | input | 1 | `codeIn` holds a sample this cycle |
| codeIn | input | 12 | Tracking oscillator control code (coarse in bits 11:6, fine in bits 5:0) |
| outCode | output | 12 | Held control code for the output oscillator |
| updStrobe | output | 1 | One-cycle pulse when `outCode` is reloaded |

## Verification
Two things can fall in the same cycle. The last sample of a window can set a new extreme, and that same sample also closes the window and loads the output. The bench places the window's largest or smallest code in the final slot. It then checks that the loaded midpoint includes that sample. The bench also checks that the window after a commit is seeded from its own first sample, so that the close of one window and the seeding of the next cannot mix.

// File: rtl/codeMidFilter_pkg.sv
package codeMidFilter_pkg;
  // strobes from window control to the extreme/midpoint datapath
  typedef struct packed {
    logic take;   // a valid sample is present
    logic first;  // sample opens a window: seed extremes
    logic last;   // sample closes a window: commit midpoint
  } winCtl_t;
endpackage

// File: rtl/codeMidCtl.sv
module codeMidCtl
  import codeMidFilter_pkg::*;
#(
  parameter int WIN_LEN = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    codeValid,
  output winCtl_t ctl
);
  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] sampleIdx;

  always_comb begin
    ctl.take  = codeValid;
    ctl.first = codeValid && (sampleIdx == '0);
    ctl.last  = codeValid && (sampleIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleIdx <= '0;
    end else if (codeValid) begin
      sampleIdx <= (sampleIdx == LAST_IDX) ? '0 : sampleIdx + 1'b1;
    end
  end
endmodule

// File: rtl/codeMidPath.sv
module codeMidPath
  import codeMidFilter_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  winCtl_t           ctl,
  output logic [CODE_W-1:0] outCode,
  output logic              updStrobe
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] maxReg, minReg, nxtMax, nxtMin;
  logic [SUM_W-1:0]  extSum;
  logic [CODE_W-1:0] midVal;

  always_comb begin
    if (ctl.first) begin
      nxtMax = codeIn;
      nxtMin = codeIn;
    end else begin
      nxtMax = (codeIn > maxReg) ? codeIn : maxReg;
      nxtMin = (codeIn < minReg) ? codeIn : minReg;
    end
    extSum = {1'b0, nxtMax} + {1'b0, nxtMin};
    midVal = extSum[SUM_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maxReg    <= '0;
      minReg    <= '0;
      outCode   <= MID_CODE;
      updStrobe <= 1'b0;
    end else begin
      updStrobe <= ctl.last;
      if (ctl.take) begin
        maxReg <= nxtMax;
        minReg <= nxtMin;
      end
      if (ctl.last) outCode <= midVal;
    end
  end
endmodule

// File: rtl/codeMidFilter.sv
module codeMidFilter
  import codeMidFilter_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int WIN_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] codeIn,
  output logic [CODE_W-1:0] outCode,
  output logic              updStrobe
);
  winCtl_t winCtl;

  codeMidCtl #(.WIN_LEN(WIN_LEN)) u_ctl (
    .clk(clk), .rst(rst), .codeValid(codeValid), .ctl(winCtl)
  );

  codeMidPath #(.CODE_W(CODE_W)) u_path (
    .clk(clk), .rst(rst), .codeIn(codeIn), .ctl(winCtl),
    .outCode(outCode), .updStrobe(updStrobe)
  );
endmodule

// File: rtl/codeMidFilter_chk.sv
module codeMidFilter_chk #(
  parameter int CODE_W  = 12,
  parameter int WIN_LEN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              codeValid,
  input logic [CODE_W-1:0] outCode,
  input logic              updStrobe
);
  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CNT_W-1:0] seenCnt;

  always_ff @(posedge clk) begin
    if (rst) seenCnt <= '0;
    else if (codeValid)
      seenCnt <= (seenCnt == CNT_W'(WIN_LEN - 1)) ? '0 : seenCnt + 1'b1;
  end

  AST_RESET_MID: assert property (@(posedge clk)
    rst |=> (outCode == MID_CODE && !updStrobe)); // R1

  AST_STROBE_AT_WINDOW_END: assert property (@(posedge clk) disable iff (rst)
    updStrobe |-> ($past(codeValid) && $past(seenCnt) == CNT_W'(WIN_LEN - 1))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (updStrobe && WIN_LEN > 1) |=> !updStrobe); // R3

  AST_INVALID_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !codeValid |=> !updStrobe); // R4

  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !updStrobe |-> outCode == $past(outCode)); // R8
endmodule

bind codeMidFilter codeMidFilter_chk #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) u_chk (
  .clk(clk), .rst(rst), .codeValid(codeValid), .outCode(outCode), .updStrobe(updStrobe)
);

// File: tb/codeMidFilter_tb.sv
module codeMidFilter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 12;
  localparam int WIN_LEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic codeValid = 1'b0;
  logic [CODE_W-1:0] codeIn = '0;
  logic [CODE_W-1:0] outCode;
  logic updStrobe;

  int checks = 0;
  int failures = 0;
  int lastOut = 2048;

  always #(CLK_PERIOD/2) clk = ~clk;

  codeMidFilter #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) u_dut (
    .clk(clk), .rst(rst), .codeValid(codeValid), .codeIn(codeIn),
    .outCode(outCode), .updStrobe(updStrobe)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushSample(input int code, input logic vld);
    @(negedge clk);
    codeIn = CODE_W'(code);
    codeValid = vld;
    @(posedge clk);
    #1;
  endtask

  // one window of samples; optional invalid cycles with extreme codes between them
  task automatic runWindow(input int w[WIN_LEN], input bit gaps, input string tag);
    int mx = w[0];
    int mn = w[0];
    for (int i = 0; i < WIN_LEN; i++) begin
      if (w[i] > mx) mx = w[i];
      if (w[i] < mn) mn = w[i];
    end
    for (int i = 0; i < WIN_LEN; i++) begin
      if (gaps) begin
        pushSample((i % 2 == 0) ? 4095 : 0, 1'b0);
        checkEq({tag, " R4 invalid no strobe"}, updStrobe, 0);
        checkEq({tag, " R4 invalid holds out"}, outCode, lastOut);
      end
      pushSample(w[i], 1'b1);
      if (i < WIN_LEN - 1) begin
        checkEq({tag, " R2 no strobe mid-window"}, updStrobe, 0);
        checkEq({tag, " R8 out held mid-window"}, outCode, lastOut);
      end else begin
        checkEq({tag, " R3 strobe at window end"}, updStrobe, 1);
        checkEq({tag, " R3 midpoint"}, outCode, (mx + mn) / 2);
        lastOut = (mx + mn) / 2;
      end
    end
    @(negedge clk);
    codeValid = 1'b0;
    @(posedge clk);
    #1;
    checkEq({tag, " R3 strobe one cycle"}, updStrobe, 0);
    checkEq({tag, " R8 out held after"}, outCode, lastOut);
  endtask

  task automatic t_reset();
    checkEq("R1 out mid during reset", outCode, 2048);
    checkEq("R1 strobe low during reset", updStrobe, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    checkEq("R1 out mid after reset", outCode, 2048);
    checkEq("R1 strobe low after reset", updStrobe, 0);
  endtask

  task automatic t_basic();
    int w[WIN_LEN] = '{1000, 1003, 998, 1001, 1002, 999, 1000, 1001};
    runWindow(w, 1'b0, "basic");
  endtask

  task automatic t_gaps();
    int w[WIN_LEN] = '{300, 310, 305, 320, 290, 315, 300, 301};
    runWindow(w, 1'b1, "gaps");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      pushSample(4095 - i, 1'b0);
      checkEq("R8 idle no strobe", updStrobe, 0);
      checkEq("R8 idle out held", outCode, lastOut);
    end
  endtask

  task automatic t_fresh();
    int hi[WIN_LEN] = '{3000, 3100, 3050, 3200, 3010, 3020, 3030, 3040};
    int lo[WIN_LEN] = '{100, 120, 110, 130, 105, 115, 125, 101};
    runWindow(hi, 1'b0, "R5 high window");
    runWindow(lo, 1'b0, "R5 low window not carried");
  endtask

  task automatic t_lastExtreme();
    int a[WIN_LEN] = '{500, 510, 505, 502, 508, 501, 503, 900};
    int b[WIN_LEN] = '{800, 810, 805, 802, 808, 801, 803, 10};
    runWindow(a, 1'b0, "R6 max last");
    runWindow(b, 1'b0, "R6 min last");
  endtask

  task automatic t_fullScale();
    int a[WIN_LEN] = '{4095, 4094, 4095, 4094, 4095, 4094, 4095, 4094};
    int b[WIN_LEN] = '{4095, 0, 2000, 100, 4000, 1, 4094, 3};
    int c[WIN_LEN] = '{7, 7, 7, 7, 7, 7, 7, 7};
    runWindow(a, 1'b0, "R7 top codes");
    checkEq("R7 top codes value", outCode, 4094);
    runWindow(b, 1'b0, "R7 full span");
    checkEq("R7 full span value", outCode, 2047);
    runWindow(c, 1'b0, "R7 flat");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog R1-R8 run actual=timeout expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(posedge clk);
    @(posedge clk);
    #1;
    t_reset();
    t_basic();
    t_gaps();
    t_idle();
    t_fresh();
    t_lastExtreme();
    t_fullScale();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule